// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit entries, each a small state machine. A short global history register holds the outcomes of the most recently resolved branches. That history picks one of several banks of entries, and the low index bits of the fetch address pick the entry within the bank.

The front end offers an address on the lookup stream. The guess comes back one cycle later on the prediction stream, together with the history value used to make it. The caller holds that history value while the branch is in flight. When the branch resolves in execute, the caller presents the real outcome on the update port with the same address bits and the same history value, so the write lands on the entry that was read. Only updates change the table and the history. Lookups never change them.

The lookup stream and the prediction stream follow valid/ready rules. A lookup is accepted when `lookup_valid` and `lookup_ready` are both high at a rising edge. `lookup_ready` is high whenever the prediction register is empty or is being drained in the same cycle. While `pred_valid` is high and `pred_ready` is low, the prediction stays where it is and no new lookup is taken. The update port has no ready signal: it is accepted in every cycle that `upd_valid` is high.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every entry is in state 2'b00 (predict not taken, last guess right), the history register is zero and `pred_valid` is low.
- R2: An accepted lookup drives `pred_valid` high in the next cycle. `pred_taken` is then bit 1 of the entry at index {history, `lookup_pc_idx`}, with history in the upper bits and the history taken as it stood in the acceptance cycle.
- R3: An entry is coded {direction, missed}, where direction 1 means taken and missed 1 means the last guess was wrong. An update whose outcome equals the direction bit leaves the direction unchanged and clears the missed bit.
- R4: An update whose outcome differs from the direction bit of an entry with missed = 0 keeps the direction and sets missed, so one miss never changes the prediction.
- R5: An update whose outcome differs from the direction bit of an entry with missed = 1 inverts the direction and clears missed, so the guess flips after two misses in a row.
- R6: Each update shifts its outcome into the history at bit 0, and older bits move toward the MSB. A lookup leaves the history unchanged. `pred_hist` reports the history value used for the prediction.
- R7: An update writes the entry at {`upd_hist`, `upd_pc_idx`}, whatever the current history is. Entries in other history banks for the same address are left unchanged.
- R8: When a lookup and an update hit the same entry in one cycle, the prediction carries the entry's value from before that update.
- R9: `lookup_ready` equals !`pred_valid` || `pred_ready`. While `pred_valid` is high and `pred_ready` is low, `pred_valid`, `pred_taken` and `pred_hist` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Lookup request present |
| lookup_ready | output | 1 | Lookup can be accepted this cycle |
| lookup_pc_idx | input | PC_IDX_W | Fetch address index bits |
| pred_valid | output | 1 | Prediction present |
| pred_ready | input | 1 | Consumer takes the prediction |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc_idx | input | PC_IDX_W | Index bits of the resolved branch address |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History returned from the prediction |

## Verification
The hardest case to reach from the ports is a lookup that reads a chosen entry while an update writes that same entry in the same cycle. Every update also shifts the history that the lookup uses to index the table. To reach this case, the stimulus first trains the target entry. It then steers the history to a known value by sending throw-away outcomes for an unrelated address. Finally it issues the lookup and the update for the target entry in one cycle. Randomised traffic with stalls on the prediction stream then runs against a behavioural model, compared every clock.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Entry coding: bit 1 = predicted direction, bit 0 = last guess missed
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b00;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic outcome);
    ctr_t nxt;
    if (cur[1] == outcome)
      nxt = {cur[1], 1'b0};
    else if (!cur[0])
      nxt = {cur[1], 1'b1};
    else
      nxt = {~cur[1], 1'b0};
    return nxt;
  endfunction

endpackage

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W == 1) begin : g_single
      assign hist_d = bit_in;
    end else begin : g_shift
      assign hist_d = {hist_q[HIST_W-2:0], bit_in};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)
      hist_q <= '0;
    else if (shift_en)
      hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_state,
  input  logic [IDX_W-1:0] up_idx,
  output ctr_t             up_state,
  input  logic             wr_en,
  input  ctr_t             wr_state
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem_q[up_idx] <= wr_state;
    end
  end

  assign rd_state = mem_q[rd_idx];
  assign up_state = mem_q[up_idx];
endmodule

// File: rtl/bp_resp.sv
module bp_resp #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              taken_in,
  input  logic [HIST_W-1:0] hist_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_taken,
  output logic [HIST_W-1:0] out_hist
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_hist  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_taken <= taken_in;
      out_hist  <= hist_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_IDX_W = 8,
  parameter int HIST_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lookup_valid,
  output logic                lookup_ready,
  input  logic [PC_IDX_W-1:0] lookup_pc_idx,
  output logic                pred_valid,
  input  logic                pred_ready,
  output logic                pred_taken,
  output logic [HIST_W-1:0]   pred_hist,
  input  logic                upd_valid,
  input  logic [PC_IDX_W-1:0] upd_pc_idx,
  input  logic                upd_taken,
  input  logic [HIST_W-1:0]   upd_hist
);
  localparam int IDX_W = PC_IDX_W + HIST_W;

  logic [HIST_W-1:0] hist_w;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  up_idx;
  ctr_t              rd_state;
  ctr_t              up_state;
  ctr_t              wr_state;
  logic              accept;

  assign lookup_ready = !pred_valid || pred_ready;
  assign accept       = lookup_valid && lookup_ready;
  assign rd_idx       = {hist_w, lookup_pc_idx};
  assign up_idx       = {upd_hist, upd_pc_idx};
  assign wr_state     = ctr_next(up_state, upd_taken);

  bp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .bit_in   (upd_taken),
    .hist_o   (hist_w)
  );

  bp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_state (rd_state),
    .up_idx   (up_idx),
    .up_state (up_state),
    .wr_en    (upd_valid),
    .wr_state (wr_state)
  );

  bp_resp #(.HIST_W(HIST_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .taken_in  (rd_state[1]),
    .hist_in   (hist_w),
    .out_ready (pred_ready),
    .out_valid (pred_valid),
    .out_taken (pred_taken),
    .out_hist  (pred_hist)
  );
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int HIST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookup_valid,
  input logic              lookup_ready,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist
);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready) |-> !lookup_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_ready) |=>
      (pred_valid && $stable(pred_taken) && $stable(pred_hist)));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_ready) |=> pred_valid);

  p_pred_hist_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_ready) |=> (pred_hist == $past(hist)));

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hist == HIST_W'({$past(hist), $past(upd_taken)})));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));
endmodule

bind branch_dir_predictor bp_checker #(.HIST_W(HIST_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookup_valid (lookup_valid),
  .lookup_ready (lookup_ready),
  .pred_valid   (pred_valid),
  .pred_ready   (pred_ready),
  .pred_taken   (pred_taken),
  .pred_hist    (pred_hist),
  .upd_valid    (upd_valid),
  .upd_taken    (upd_taken),
  .hist         (hist_w)
);

// File: tb/tb_branch_dir_predictor.sv
module tb_branch_dir_predictor;
  localparam int K  = 8;
  localparam int H  = 2;
  localparam int NE = 1 << (K + H);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lookup_valid = 1'b0;
  logic         lookup_ready;
  logic [K-1:0] lookup_pc_idx = '0;
  logic         pred_valid;
  logic         pred_ready = 1'b1;
  logic         pred_taken;
  logic [H-1:0] pred_hist;
  logic         upd_valid = 1'b0;
  logic [K-1:0] upd_pc_idx = '0;
  logic         upd_taken = 1'b0;
  logic [H-1:0] upd_hist = '0;

  int total = 0;
  int bad = 0;

  // reference model state
  int     m_tbl [NE];
  int     m_hist = 0;
  logic   m_pv = 1'b0;
  logic   m_pt = 1'b0;
  int     m_ph = 0;

  always #4 clk = ~clk;

  branch_dir_predictor #(.PC_IDX_W(K), .HIST_W(H)) dut (
    .clk(clk), .rst_n(rst_n),
    .lookup_valid(lookup_valid), .lookup_ready(lookup_ready),
    .lookup_pc_idx(lookup_pc_idx),
    .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc_idx(upd_pc_idx),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // entry update rule taken from R3..R5
  function automatic int rule(input int s, input int outcome);
    int dir = s / 2;
    int missed = s % 2;
    if (dir == outcome) return dir * 2;
    if (missed == 0) return dir * 2 + 1;
    return (1 - dir) * 2;
  endfunction

  // one clock: check ready, advance model at edge, compare outputs
  task automatic cyc();
    int lk_idx;
    int up_idx;
    #1;
    check("R9 lookup_ready", int'(lookup_ready), int'(!m_pv || pred_ready));
    @(posedge clk);
    if (rst_n) begin
      if (lookup_valid && (!m_pv || pred_ready)) begin
        lk_idx = m_hist * (1 << K) + int'(lookup_pc_idx);
        m_pt = m_tbl[lk_idx] / 2;
        m_ph = m_hist;
        m_pv = 1'b1;
      end else if (pred_ready) begin
        m_pv = 1'b0;
      end
      if (upd_valid) begin
        up_idx = int'(upd_hist) * (1 << K) + int'(upd_pc_idx);
        m_tbl[up_idx] = rule(m_tbl[up_idx], int'(upd_taken));
        m_hist = (m_hist * 2 + int'(upd_taken)) % (1 << H);
      end
    end
    @(negedge clk);
    check("R9 pred_valid", int'(pred_valid), int'(m_pv));
    if (m_pv) begin
      check("R2 pred_taken", int'(pred_taken), int'(m_pt));
      check("R6 pred_hist", int'(pred_hist), m_ph);
    end
  endtask

  task automatic upd(input int h, input int pc, input int t);
    upd_valid = 1'b1; upd_hist = H'(h); upd_pc_idx = K'(pc); upd_taken = t[0];
    cyc();
    upd_valid = 1'b0;
  endtask

  task automatic force_hist(input int t);
    upd(0, 200, t);
    upd(0, 200, t);
  endtask

  task automatic look(input int pc, input int exp, input string req);
    lookup_valid = 1'b1; lookup_pc_idx = K'(pc); pred_ready = 1'b1;
    cyc();
    lookup_valid = 1'b0;
    check(req, int'(pred_taken), exp);
    cyc();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) m_tbl[i] = 0;
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 pred_valid after reset", int'(pred_valid), 0);
    look(5, 0, "R1 initial entry not taken");
    check("R1 history zero", int'(pred_hist), 0);

    // hysteresis on entry (hist 3, pc 5)
    upd(3, 5, 1); force_hist(1);
    look(5, 0, "R4 single miss keeps direction");
    check("R6 history after two taken", int'(pred_hist), 3);
    upd(3, 5, 1); force_hist(1);
    look(5, 1, "R5 second miss flips");
    upd(3, 5, 1); upd(3, 5, 0); force_hist(1);
    look(5, 1, "R4 miss from right state");
    upd(3, 5, 1); upd(3, 5, 0); upd(3, 5, 0); force_hist(1);
    look(5, 0, "R3 R5 correct then two misses");

    // bank selection
    upd(3, 5, 1); upd(3, 5, 1);
    force_hist(0);
    look(5, 0, "R7 other bank untouched");
    force_hist(1);
    look(5, 1, "R7 trained bank");

    // same-cycle lookup and update of one entry
    upd(3, 5, 0); force_hist(1);
    lookup_valid = 1'b1; lookup_pc_idx = K'(5);
    upd_valid = 1'b1; upd_hist = 2'd3; upd_pc_idx = K'(5); upd_taken = 1'b0;
    cyc();
    lookup_valid = 1'b0; upd_valid = 1'b0;
    check("R8 old value on collision", int'(pred_taken), 1);
    cyc();
    force_hist(1);
    look(5, 0, "R8 entry written after collision");

    // back-pressure
    pred_ready = 1'b0; lookup_valid = 1'b1; lookup_pc_idx = K'(5);
    cyc();
    for (int i = 0; i < 4; i++) begin
      lookup_pc_idx = K'(i + 40);
      cyc();
      check("R9 stalled ready low", int'(lookup_ready), 0);
      check("R9 stalled value held", int'(pred_taken), 0);
    end
    lookup_valid = 1'b0; pred_ready = 1'b1;
    cyc();

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      lookup_valid  = ($urandom % 3) != 0;
      lookup_pc_idx = K'($urandom % 8);
      pred_ready    = ($urandom % 4) != 0;
      upd_valid     = ($urandom % 2) != 0;
      upd_pc_idx    = K'($urandom % 8);
      upd_hist      = H'($urandom);
      upd_taken     = ($urandom % 3) != 0;
      cyc();
    end
    lookup_valid = 1'b0; upd_valid = 1'b0;
    cyc();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule